// File: doc/BRIEF.md
# Security-Aware Interrupt Priority Byte Store

This block holds an 8-bit priority value for each shared interrupt of an interrupt controller. A register bus reaches it one byte at a time, which touches one interrupt, or one 32-bit word at a time, which touches four interrupts with consecutive IDs. Every access carries a secure attribute. When the security split is active, a non-secure access sees a remapped view of each priority. It may touch only interrupts that a neighbouring block marks as group 1. Priorities of other interrupts read as zero to it and ignore its writes.

IDs below the first shared interrupt (32) and IDs at or above the implemented count have no storage. The group membership vector and the security-disable bit come from neighbouring logic. Arbitration between priorities happens elsewhere. After each write that stores at least one byte, the block emits a one-cycle event that carries the lowest interrupt ID written, so that downstream logic can re-evaluate that interrupt.

Top module: `prio_byte_rf`

## Requirements
- R1: After reset every stored priority is 0x00, and no read-valid or write event is raised until a bus strobe arrives.
- R2: A secure access, or any access while `sec_off_i` is 1, reads and writes the stored byte unchanged.
- R3: A non-secure access while `sec_off_i` is 0 that writes an interrupt whose `grp1_i` bit is 1 stores 0x80 OR (written byte >> 1).
- R4: A non-secure read while `sec_off_i` is 0 of an interrupt whose `grp1_i` bit is 1 returns (stored << 1) truncated to 8 bits.
- R5: A non-secure access while `sec_off_i` is 0 to an interrupt whose `grp1_i` bit is 0 reads as 0x00, and a write leaves the stored value unchanged.
- R6: A byte access (`bus_word_i`=0) to an ID below 32 or at or above NUM_IRQ reads 0x00 and its write is ignored. Byte reads return the value in bits [7:0] with the upper 24 bits zero.
- R7: A word access (`bus_word_i`=1) at ID n covers IDs n..n+3. ID n sits in bits [7:0], n+1 in [15:8], n+2 in [23:16] and n+3 in [31:24].
- R8: A word write is dropped entirely when n is below 32 or n+3 is at or above NUM_IRQ. A word read returns 0x00 in each lane whose ID is out of range and returns the normal view in the other lanes.
- R9: A write takes effect at the clock edge that samples the strobe. A read returns its data in `rd_data_o`, with `rd_valid_o` high, for exactly the cycle after that edge.
- R10: `wr_evt_o` pulses for one cycle after a write that stored at least one byte, and `wr_evt_id_o` then holds the lowest ID stored. A write that stores nothing raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 1 | 1 = four-byte word, 0 = single byte |
| bus_secure_i | input | 1 | Secure attribute of the access |
| bus_id_i | input | ID_W (10) | Interrupt ID of the byte, or of the lowest lane of a word |
| bus_wdata_i | input | 32 | Write data; a byte write uses bits [7:0] |
| sec_off_i | input | 1 | Security split disabled; all accesses then see raw values |
| grp1_i | input | NUM_IRQ (64) | Per-interrupt group bit; 1 = reachable by non-secure accesses |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| wr_evt_o | output | 1 | A write stored at least one byte |
| wr_evt_id_o | output | ID_W (10) | Lowest interrupt ID stored by that write |

## Verification
On every cycle, the assertions check three things. A non-secure store always has its top bit set. A non-secure read never shows a set low bit in any lane. A word write that is out of range enables no lane, and reads of reserved byte IDs return zero. The assertions also tie every write event and read-valid back to a strobe one cycle earlier. Only the bench's scenarios can show that the shift arithmetic round-trips correctly and that blocked writes leave the earlier secure value in place. They also show that the lane order of word accesses, and the lowest-ID rule for the event, match a reference model under changing group and security-disable settings.

// File: rtl/prio_rf_pkg.sv
package prio_rf_pkg;

  localparam int PRIO_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = PRIO_W * LANES;

  typedef logic [PRIO_W-1:0] prio_t;

  // view of a stored priority as seen by a non-secure reader
  function automatic prio_t ns_read_view(input prio_t stored);
    return {stored[PRIO_W-2:0], 1'b0};
  endfunction

  // value stored when a non-secure writer presents a priority
  function automatic prio_t ns_write_view(input prio_t written);
    return {1'b1, written[PRIO_W-1:1]};
  endfunction

endpackage

// File: rtl/prio_lane_gate.sv
module prio_lane_gate
  import prio_rf_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int FIRST_ID = 32,
  parameter int ID_W     = 10
) (
  input  logic [ID_W:0] lane_id_i,
  input  logic          ns_view_i,
  input  logic          grp1_i,
  input  prio_t         stored_i,
  input  logic          wreq_i,
  input  prio_t         wbyte_i,
  output logic          in_range_o,
  output prio_t         rd_byte_o,
  output logic          we_o,
  output prio_t         wbyte_o
);

  localparam logic [ID_W:0] LO_ID = (ID_W+1)'(FIRST_ID);
  localparam logic [ID_W:0] HI_ID = (ID_W+1)'(NUM_IRQ);

  logic blocked;

  assign in_range_o = (lane_id_i >= LO_ID) && (lane_id_i < HI_ID);
  assign blocked    = ns_view_i && !grp1_i;

  always_comb begin
    rd_byte_o = '0;
    if (in_range_o && !blocked) begin
      rd_byte_o = ns_view_i ? ns_read_view(stored_i) : stored_i;
    end
  end

  assign we_o    = wreq_i && in_range_o && !blocked;
  assign wbyte_o = ns_view_i ? ns_write_view(wbyte_i) : wbyte_i;

endmodule

// File: rtl/prio_byte_store.sv
module prio_byte_store
  import prio_rf_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int FIRST_ID = 32,
  parameter int ID_W     = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0][ID_W:0]    lane_id_i,
  input  logic [LANES-1:0]            we_i,
  input  logic [LANES-1:0][PRIO_W-1:0] wbyte_i,
  output logic [LANES-1:0][PRIO_W-1:0] rbyte_o
);

  localparam int NSTORE = NUM_IRQ - FIRST_ID;
  localparam int SIDX_W = (NSTORE > 1) ? $clog2(NSTORE) : 1;
  localparam logic [ID_W:0] LO_ID = (ID_W+1)'(FIRST_ID);
  localparam logic [ID_W:0] HI_ID = (ID_W+1)'(NUM_IRQ);

  prio_t cell_w [NSTORE];

  for (genvar e = 0; e < NSTORE; e++) begin : g_cell
    localparam logic [ID_W:0] MY_ID = (ID_W+1)'(FIRST_ID + e);
    prio_t cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cell_q <= '0;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (we_i[l] && (lane_id_i[l] == MY_ID)) cell_q <= wbyte_i[l];
        end
      end
    end
    assign cell_w[e] = cell_q;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rbyte_o[l] = '0;
      if ((lane_id_i[l] >= LO_ID) && (lane_id_i[l] < HI_ID)) begin
        rbyte_o[l] = cell_w[SIDX_W'(lane_id_i[l] - LO_ID)];
      end
    end
  end

endmodule

// File: rtl/prio_byte_rf.sv
module prio_byte_rf
  import prio_rf_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int FIRST_ID = 32,
  parameter int ID_W     = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic               bus_word_i,
  input  logic               bus_secure_i,
  input  logic [ID_W-1:0]    bus_id_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic               sec_off_i,
  input  logic [NUM_IRQ-1:0] grp1_i,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               wr_evt_o,
  output logic [ID_W-1:0]    wr_evt_id_o
);

  localparam int GIDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W:0] LO_ID = (ID_W+1)'(FIRST_ID);
  localparam logic [ID_W:0] HI_ID = (ID_W+1)'(NUM_IRQ);

  // named internal events
  logic                          ns_view;
  logic                          wr_strobe;
  logic                          rd_strobe;
  logic                          word_ok;
  logic [LANES-1:0][ID_W:0]      lane_id;
  logic [LANES-1:0]              lane_act;
  logic [LANES-1:0]              lane_grp;
  logic [LANES-1:0]              lane_wreq;
  logic [LANES-1:0]              lane_we;
  logic [LANES-1:0]              lane_inr;
  logic [LANES-1:0][PRIO_W-1:0]  lane_stored;
  logic [LANES-1:0][PRIO_W-1:0]  lane_rd;
  logic [LANES-1:0][PRIO_W-1:0]  lane_wbyte;
  logic [DATA_W-1:0]             rd_next;
  logic                          evt_next;
  logic [ID_W-1:0]               evt_id_next;

  assign ns_view   = !bus_secure_i && !sec_off_i;
  assign wr_strobe = bus_valid_i && bus_write_i;
  assign rd_strobe = bus_valid_i && !bus_write_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_id[l]  = {1'b0, bus_id_i} + (ID_W+1)'(l);
    assign lane_act[l] = (l == 0) ? 1'b1 : bus_word_i;
    assign lane_grp[l] = (lane_id[l] < HI_ID) ? grp1_i[GIDX_W'(lane_id[l])] : 1'b0;
    assign lane_wreq[l] = wr_strobe && lane_act[l] && (!bus_word_i || word_ok);

    prio_lane_gate #(
      .NUM_IRQ (NUM_IRQ),
      .FIRST_ID(FIRST_ID),
      .ID_W    (ID_W)
    ) gate_i (
      .lane_id_i (lane_id[l]),
      .ns_view_i (ns_view),
      .grp1_i    (lane_grp[l]),
      .stored_i  (lane_stored[l]),
      .wreq_i    (lane_wreq[l]),
      .wbyte_i   (bus_wdata_i[l*PRIO_W +: PRIO_W]),
      .in_range_o(lane_inr[l]),
      .rd_byte_o (lane_rd[l]),
      .we_o      (lane_we[l]),
      .wbyte_o   (lane_wbyte[l])
    );
  end

  // the whole word must lie inside the shared range
  assign word_ok = (lane_id[0] >= LO_ID) && (lane_id[LANES-1] < HI_ID);

  prio_byte_store #(
    .NUM_IRQ (NUM_IRQ),
    .FIRST_ID(FIRST_ID),
    .ID_W    (ID_W)
  ) store_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_id_i(lane_id),
    .we_i     (lane_we),
    .wbyte_i  (lane_wbyte),
    .rbyte_o  (lane_stored)
  );

  always_comb begin
    rd_next = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_act[l]) rd_next[l*PRIO_W +: PRIO_W] = lane_rd[l];
    end
  end

  // lowest lane that stores a byte names the event
  always_comb begin
    evt_next    = |lane_we;
    evt_id_next = '0;
    for (int l = LANES-1; l >= 0; l--) begin
      if (lane_we[l]) evt_id_next = lane_id[l][ID_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
      wr_evt_o    <= 1'b0;
      wr_evt_id_o <= '0;
    end else begin
      rd_valid_o <= rd_strobe;
      if (rd_strobe) rd_data_o <= rd_next;
      wr_evt_o <= evt_next;
      if (evt_next) wr_evt_id_o <= evt_id_next;
    end
  end

  // ---------------- assertions ----------------
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    p_ns_store_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_we[l] && ns_view) |-> lane_wbyte[l][PRIO_W-1]);

    p_ns_read_lsb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_strobe && ns_view) |=> (rd_data_o[l*PRIO_W] == 1'b0));

    p_stored_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_we[l] |-> lane_inr[l]);
  end

  p_word_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe && bus_word_i &&
     ((lane_id[0] < LO_ID) || (lane_id[LANES-1] >= HI_ID))) |-> (lane_we == '0));

  p_byte_reserved_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe && !bus_word_i && (lane_id[0] < LO_ID)) |=> (rd_data_o == '0));

  p_rd_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_strobe));

  p_evt_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_o |-> $past(wr_strobe));

  p_byte_one_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe && !bus_word_i) |-> ($countones(lane_we) <= 1));

endmodule

// File: tb/prio_byte_rf_tb.sv
module prio_byte_rf_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NIRQ  = 64;
  localparam int FIRST = 32;
  localparam int IDW   = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0, wr = 1'b0, word = 1'b0, sec = 1'b0, ds = 1'b0;
  logic [IDW-1:0]  id = '0;
  logic [31:0]     wdata = '0;
  logic [NIRQ-1:0] grp = '0;
  logic            rvalid, evt;
  logic [31:0]     rdata;
  logic [IDW-1:0]  evt_id;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int model [NIRQ];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_byte_rf #(.NUM_IRQ(NIRQ), .FIRST_ID(FIRST), .ID_W(IDW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
    .bus_word_i(word), .bus_secure_i(sec), .bus_id_i(id), .bus_wdata_i(wdata),
    .sec_off_i(ds), .grp1_i(grp), .rd_valid_o(rvalid), .rd_data_o(rdata),
    .wr_evt_o(evt), .wr_evt_id_o(evt_id)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16]) % m;
  endfunction

  function automatic bit ns_on();
    return !sec && !ds;
  endfunction

  // expected byte seen by a read of interrupt n
  function automatic int exp_byte(input int n);
    if (n < FIRST || n >= NIRQ) return 0;
    if (ns_on()) begin
      if (!grp[n]) return 0;
      return (model[n] * 2) % 256;
    end
    return model[n];
  endfunction

  // apply a write to the model; returns lowest ID stored or -1
  function automatic int model_write(input int n, input bit is_word, input logic [31:0] d);
    int first = -1;
    int cnt = is_word ? 4 : 1;
    if (is_word && (n < FIRST || n + 3 >= NIRQ)) return -1;
    for (int k = 0; k < cnt; k++) begin
      int t = n + k;
      int v = int'(d[8*k +: 8]);
      if (t < FIRST || t >= NIRQ) continue;
      if (ns_on() && !grp[t]) continue;
      model[t] = ns_on() ? 128 + v / 2 : v;
      if (first < 0) first = t;
    end
    return first;
  endfunction

  task automatic op(input bit w, input bit is_word, input int n, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; wr = w; word = is_word; id = IDW'(n); wdata = d;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic do_write(input bit is_word, input int n, input logic [31:0] d,
                          input string req);
    int f;
    op(1'b1, is_word, n, d);
    f = model_write(n, is_word, d);
    check(evt == (f >= 0), {req, " R10 event"}, {31'd0, evt}, {31'd0, f >= 0});
    if (f >= 0) check(evt_id == IDW'(f), {req, " R10 event id"}, 32'(evt_id), 32'(f));
  endtask

  task automatic do_read(input bit is_word, input int n, input string req);
    logic [31:0] e = '0;
    e[7:0] = 8'(exp_byte(n));
    if (is_word) for (int k = 1; k < 4; k++) e[8*k +: 8] = 8'(exp_byte(n + k));
    op(1'b0, is_word, n, 32'h0);
    check(rvalid === 1'b1, {req, " R9 valid"}, {31'd0, rvalid}, 32'd1);
    check(rdata === e, req, rdata, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NIRQ; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    check(rvalid == 1'b0 && evt == 1'b0, "R1 idle outputs", {30'd0, rvalid, evt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rvalid == 1'b0 && evt == 1'b0, "R1 idle after reset", {30'd0, rvalid, evt}, 32'd0);

    // R1: all priorities zero, secure view
    sec = 1'b1;
    for (int i = 0; i < NIRQ + 4; i++) do_read(1'b0, i, "R1 reset value");

    // R2 / R6: secure byte writes across the whole space incl. reserved IDs
    for (int i = 0; i < NIRQ + 8; i++) do_write(1'b0, i, 32'(8'((i * 37 + 5) % 256)), "R6 byte write");
    do_write(1'b0, 1023, 32'h5A, "R6 top id write");
    for (int i = 0; i < NIRQ + 8; i++) do_read(1'b0, i, "R2 raw byte read");

    // R7 / R8: word writes at every start ID, then word reads
    for (int i = 24; i < NIRQ + 2; i++) do_write(1'b1, i, 32'h11223344 + 32'(i * 32'h01010101), "R8 word write");
    for (int i = 24; i < NIRQ + 2; i++) do_read(1'b1, i, "R7 word read lanes");
    do_read(1'b1, 1022, "R8 word read beyond top");

    // R3 / R4 / R5: non-secure with alternating groups
    grp = 64'hA5A5_F00F_3C3C_9669;
    sec = 1'b0; ds = 1'b0;
    for (int i = FIRST; i < NIRQ; i++) do_read(1'b0, i, "R4 R5 ns byte read");
    for (int i = FIRST; i < NIRQ; i++) do_write(1'b0, i, 32'(8'(i * 11)), "R3 R5 ns byte write");
    for (int i = FIRST; i < NIRQ; i += 4) do_write(1'b1, i, 32'hFF01_7F80 ^ 32'(i), "R3 ns word write");
    sec = 1'b1;
    for (int i = FIRST; i < NIRQ; i++) do_read(1'b0, i, "R5 secure view after ns");
    sec = 1'b0;
    for (int i = FIRST - 2; i < NIRQ; i++) do_read(1'b1, i, "R4 ns word read");

    // R2: security disabled makes non-secure accesses raw
    ds = 1'b1;
    for (int i = FIRST; i < NIRQ; i++) do_write(1'b0, i, 32'(8'(255 - i)), "R2 ds write");
    for (int i = FIRST; i < NIRQ; i++) do_read(1'b0, i, "R2 ds read");

    // mixed random traffic
    for (int it = 0; it < 3000; it++) begin
      bit w = rnd(2) == 1;
      bit wd = rnd(2) == 1;
      int n = (rnd(16) == 0) ? 1016 + rnd(8) : rnd(NIRQ + 8);
      logic [31:0] d = {seed[15:0], seed[31:16]};
      sec = rnd(2) == 1;
      ds  = rnd(4) == 0;
      if (rnd(8) == 0) grp = {grp[NIRQ-2:0], grp[NIRQ-1] ^ grp[3]};
      if (w) do_write(wd, n, d, "R3 R8 random write");
      else   do_read(wd, n, "R4 R7 random read");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule